// File: doc/BRIEF.md
# Mantissa-Exponent Serial Rate Generator

This block makes the timing pulses for a serial port that works either as a UART or as an SPI master. Software stores an 8-bit mantissa M and a 5-bit exponent E. Each system clock cycle, a phase accumulator adds the step (256 + M) · 2^E. Carries out of a mode-dependent bit position become rate events. This gives a rate of F · (256 + M) · 2^E / 2^28, so fractional ratios of the system clock F are possible without an integer divider.

In UART mode the carry is taken at bit 24, which yields a tick at sixteen times the bit rate, plus a bit strobe on every sixteenth tick. In SPI master mode the carry is taken at bit 27, which yields two events per SCK period. Each event flips SCK, and the block issues a sample strobe or a shift strobe according to clock polarity and phase. The block also flags a stored rate that exceeds the limit of the selected mode. In SPI slave mode it stays quiet. The configuration is frozen while the port is active, and the phase restarts at every activation.

Top module: `baud_gen`

## Requirements
- R1: In UART mode (mode code 0), over N consecutive active cycles starting at activation, the number of tick16_o pulses is floor(N · (256+M) · 2^E / 2^24). With E=16 and M=0 there is a pulse every cycle.
- R2: bit_stb_o pulses only together with tick16_o. It marks the 16th, 32nd, ... tick since activation.
- R3: In SPI master modes (code 1 full duplex, code 2 transmit only), sck_o changes level floor(N · (256+M) · 2^E / 2^27) times over N active cycles. The SCK frequency is therefore F · (256+M) · 2^E / 2^28.
- R4: Every SCK change carries exactly one strobe. The leading edge leaves the idle level cpol, and the trailing edge returns to it. With cpha=0, sample_stb_o comes with leading edges and shift_stb_o with trailing edges. With cpha=1 the roles swap. The two strobes are never high together.
- R5: While the port is inactive, sck_o equals cpol.
- R6: rate_err_o is high exactly when the stored step exceeds the mode limit: 2^24 for UART (above E=16, M=0), 2^25 for full-duplex SPI (above E=17, M=0), and 2^27 for transmit-only SPI (above E=19, M=0). It is never high in slave mode.
- R7: A configuration write (cfg_we high) made while active is high is ignored. The stored mantissa and exponent keep their values, as seen through rate_err_o and the rate that follows.
- R8: In SPI slave mode (code 3) the block generates no SCK edges, no strobes and no ticks, whatever the configuration.
- R9: The accumulator and the SCK phase restart from zero at every activation, so each transfer begins with the same phase.
- R10: While active is low, no tick, bit strobe or SPI strobe is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | 0 UART, 1 SPI master full duplex, 2 SPI master transmit only, 3 SPI slave |
| active_i | input | 1 | Port busy with a transfer |
| cpol_i | input | 1 | SCK idle level |
| cpha_i | input | 1 | 0: sample on leading edge, 1: sample on trailing edge |
| cfg_we_i | input | 1 | Write strobe for mantissa and exponent |
| cfg_mant_i | input | 8 | Mantissa to store |
| cfg_exp_i | input | 5 | Exponent to store |
| tick16_o | output | 1 | UART oversampling tick |
| bit_stb_o | output | 1 | UART bit strobe, one per 16 ticks |
| sck_o | output | 1 | SPI serial clock |
| sample_stb_o | output | 1 | SPI receive sample strobe |
| shift_stb_o | output | 1 | SPI transmit shift strobe |
| rate_err_o | output | 1 | Stored rate illegal for the current mode |

## Verification
Two functions can fall in the same cycle. A UART tick and its bit strobe coincide on every sixteenth carry. An SCK level change coincides with its sample or shift strobe. The bench provokes both with settings that carry every cycle (E=16 in UART, E=19 in transmit-only SPI) as well as with fractional settings. In each sampled cycle it checks that a bit strobe appears only together with a tick whose running count is a multiple of sixteen. It also checks that each strobe appears only in the cycle where sck_o moves, on the side of the idle level that cpol and cpha predict.

// File: rtl/baud_gen_pkg.sv
package baud_gen_pkg;

  localparam int MANT_W    = 8;
  localparam int EXP_W     = 5;
  localparam int STEP_W    = MANT_W + 1 + (1 << EXP_W) - 1;
  localparam int FRAC_W    = 28;
  localparam int UART_CPOS = 24;
  localparam int SPI_CPOS  = 27;
  localparam int FD_LIMPOS = 25;
  localparam int OSR       = 16;

  typedef enum logic [1:0] {
    MODE_UART   = 2'd0,
    MODE_SPI_FD = 2'd1,
    MODE_SPI_TX = 2'd2,
    MODE_SPI_SL = 2'd3
  } port_mode_e;

  typedef logic [STEP_W-1:0] step_t;

  // Accumulator increment: (256 + M) shifted left by E.
  function automatic step_t step_of(input logic [MANT_W-1:0] m,
                                    input logic [EXP_W-1:0]  e);
    step_t base;
    base = step_t'({1'b1, m});
    return base << e;
  endfunction

  // Largest accumulator value before a carry is taken.
  function automatic step_t wrap_mask(input port_mode_e md);
    step_t one;
    one = step_t'(1);
    if (md == MODE_UART) return (one << UART_CPOS) - one;
    return (one << SPI_CPOS) - one;
  endfunction

  // Largest legal step for a mode.
  function automatic step_t step_ceiling(input port_mode_e md);
    step_t one;
    one = step_t'(1);
    case (md)
      MODE_UART:   return one << UART_CPOS;
      MODE_SPI_FD: return one << FD_LIMPOS;
      MODE_SPI_TX: return one << SPI_CPOS;
      default:     return '0;
    endcase
  endfunction

  function automatic logic rate_illegal(input port_mode_e md, input step_t step);
    return (md != MODE_SPI_SL) && (step > step_ceiling(md));
  endfunction

endpackage

// File: rtl/baud_cfg_reg.sv
module baud_cfg_reg #(
  parameter int MANT_W = 8,
  parameter int EXP_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active_i,
  input  logic              we_i,
  input  logic [MANT_W-1:0] mant_i,
  input  logic [EXP_W-1:0]  exp_i,
  output logic [MANT_W-1:0] mant_q,
  output logic [EXP_W-1:0]  exp_q
);

  logic take;
  assign take = we_i && !active_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mant_q <= '0;
      exp_q  <= '0;
    end else if (take) begin
      mant_q <= mant_i;
      exp_q  <= exp_i;
    end
  end

  // R7: configuration cannot move while the port is active
  p_cfg_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    active_i |=> ($stable(mant_q) && $stable(exp_q)));

endmodule

// File: rtl/baud_phase_acc.sv
module baud_phase_acc #(
  parameter int STEP_W = 40,
  parameter int FRAC_W = 28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_i,
  input  logic [STEP_W-1:0] step_i,
  input  logic [STEP_W-1:0] wrap_i,
  output logic              evt_o
);

  logic [FRAC_W-1:0] acc_q;
  logic [STEP_W:0]   sum;
  logic [STEP_W:0]   kept;
  logic              carry;

  assign sum   = {1'b0, step_i} + (STEP_W+1)'(acc_q);
  assign carry = sum > {1'b0, wrap_i};
  assign kept  = sum & {1'b0, wrap_i};
  assign evt_o = run_i && carry;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_q <= '0;
    else if (!run_i) acc_q <= '0;
    else             acc_q <= FRAC_W'(kept);
  end

  // R9: accumulator returns to zero whenever the port is idle
  p_acc_cleared_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> (acc_q == '0));

  // R1: remainder always stays below the carry position
  p_acc_in_window_r1: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |=> ({{(STEP_W-FRAC_W){1'b0}}, acc_q} <= $past(wrap_i)));

endmodule

// File: rtl/baud_uart_tick.sv
module baud_uart_tick #(
  parameter int OSR = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic evt_i,
  output logic tick_o,
  output logic bit_o
);

  localparam int CW = $clog2(OSR);

  logic [CW-1:0] cnt_q;
  logic          last;

  assign last = (cnt_q == CW'(OSR - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
      bit_o  <= 1'b0;
    end else begin
      tick_o <= evt_i;
      bit_o  <= evt_i && last;
      if (!run_i)     cnt_q <= '0;
      else if (evt_i) cnt_q <= last ? '0 : cnt_q + CW'(1);
    end
  end

  // R2: a bit strobe never stands alone
  p_bit_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bit_o |-> tick_o);

  // R10: idle port emits nothing
  p_tick_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> (!tick_o && !bit_o));

endmodule

// File: rtl/baud_spi_sck.sv
module baud_spi_sck (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic evt_i,
  input  logic cpol_i,
  input  logic cpha_i,
  output logic sck_o,
  output logic sample_o,
  output logic shift_o
);

  logic phase_q;
  logic lead_evt;
  logic trail_evt;

  assign lead_evt  = evt_i && !phase_q;
  assign trail_evt = evt_i &&  phase_q;
  assign sck_o     = phase_q ^ cpol_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= 1'b0;
      sample_o <= 1'b0;
      shift_o  <= 1'b0;
    end else begin
      sample_o <= cpha_i ? trail_evt : lead_evt;
      shift_o  <= cpha_i ? lead_evt  : trail_evt;
      if (!run_i) phase_q <= 1'b0;
      else        phase_q <= phase_q ^ evt_i;
    end
  end

  // R3: every half-period event flips the clock phase
  p_evt_flips_r3: assert property (@(posedge clk) disable iff (!rst_n)
    evt_i |=> (phase_q != $past(phase_q)));

  // R4: sample and shift are on opposite edges
  p_one_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(sample_o && shift_o));

  // R5: phase parks at the idle level when not running
  p_phase_home_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> (phase_q == 1'b0));

endmodule

// File: rtl/baud_gen.sv
module baud_gen
  import baud_gen_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_i,
  input  logic              active_i,
  input  logic              cpol_i,
  input  logic              cpha_i,
  input  logic              cfg_we_i,
  input  logic [MANT_W-1:0] cfg_mant_i,
  input  logic [EXP_W-1:0]  cfg_exp_i,
  output logic              tick16_o,
  output logic              bit_stb_o,
  output logic              sck_o,
  output logic              sample_stb_o,
  output logic              shift_stb_o,
  output logic              rate_err_o
);

  port_mode_e        md;
  logic [MANT_W-1:0] mant_q;
  logic [EXP_W-1:0]  exp_q;
  step_t             step;
  step_t             wrap;
  logic              uart_run;
  logic              spi_run;
  logic              acc_run;
  logic              rate_evt;
  logic              uart_evt;
  logic              spi_evt;

  assign md       = port_mode_e'(mode_i);
  assign step     = step_of(mant_q, exp_q);
  assign wrap     = wrap_mask(md);
  assign uart_run = active_i && (md == MODE_UART);
  assign spi_run  = active_i && ((md == MODE_SPI_FD) || (md == MODE_SPI_TX));
  assign acc_run  = uart_run || spi_run;
  assign uart_evt = rate_evt && uart_run;
  assign spi_evt  = rate_evt && spi_run;
  assign rate_err_o = rate_illegal(md, step);

  baud_cfg_reg #(.MANT_W(MANT_W), .EXP_W(EXP_W)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .active_i (active_i),
    .we_i     (cfg_we_i),
    .mant_i   (cfg_mant_i),
    .exp_i    (cfg_exp_i),
    .mant_q   (mant_q),
    .exp_q    (exp_q)
  );

  baud_phase_acc #(.STEP_W(STEP_W), .FRAC_W(FRAC_W)) u_acc (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (acc_run),
    .step_i (step),
    .wrap_i (wrap),
    .evt_o  (rate_evt)
  );

  baud_uart_tick #(.OSR(OSR)) u_uart (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (uart_run),
    .evt_i  (uart_evt),
    .tick_o (tick16_o),
    .bit_o  (bit_stb_o)
  );

  baud_spi_sck u_spi (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_i    (spi_run),
    .evt_i    (spi_evt),
    .cpol_i   (cpol_i),
    .cpha_i   (cpha_i),
    .sck_o    (sck_o),
    .sample_o (sample_stb_o),
    .shift_o  (shift_stb_o)
  );

  // R8: slave mode never reports a rate error
  p_slave_no_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (md == MODE_SPI_SL) |-> !rate_err_o);

  // R8: slave mode leaves the strobes and ticks low
  p_slave_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (md == MODE_SPI_SL) |=> (!sample_stb_o && !shift_stb_o && !tick16_o));

  // R6: any UART exponent beyond 16 is out of range
  p_uart_exp_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((md == MODE_UART) && (exp_q > EXP_W'(16))) |-> rate_err_o);

endmodule

// File: tb/baud_gen_bench.sv
module baud_gen_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] mode;
  logic       active;
  logic       cpol, cpha;
  logic       cfg_we;
  logic [7:0] cfg_mant;
  logic [4:0] cfg_exp;
  logic       tick16, bit_stb, sck, sample_stb, shift_stb, rate_err;

  always #2 clk = ~clk;

  baud_gen u_baud_gen (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .active_i(active),
    .cpol_i(cpol), .cpha_i(cpha), .cfg_we_i(cfg_we),
    .cfg_mant_i(cfg_mant), .cfg_exp_i(cfg_exp),
    .tick16_o(tick16), .bit_stb_o(bit_stb), .sck_o(sck),
    .sample_stb_o(sample_stb), .shift_stb_o(shift_stb), .rate_err_o(rate_err)
  );

  int n_run = 0;
  int n_fail = 0;
  int c_tick, c_bit, c_tog, c_smp, c_shf, c_badbit, c_badspi;

  typedef struct packed {
    logic [1:0]  md;
    logic        pol;
    logic        pha;
    logic [7:0]  m;
    logic [4:0]  e;
    logic [15:0] n;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VT [NV] = '{
    '{2'd0, 1'b0, 1'b0, 8'd0,   5'd16, 16'd40},
    '{2'd0, 1'b0, 1'b0, 8'd128, 5'd15, 16'd40},
    '{2'd0, 1'b0, 1'b0, 8'd255, 5'd10, 16'd1000},
    '{2'd0, 1'b0, 1'b0, 8'd1,   5'd16, 16'd0},
    '{2'd0, 1'b0, 1'b0, 8'd0,   5'd17, 16'd0},
    '{2'd1, 1'b0, 1'b0, 8'd0,   5'd17, 16'd40},
    '{2'd1, 1'b1, 1'b1, 8'd64,  5'd16, 16'd100},
    '{2'd1, 1'b0, 1'b0, 8'd1,   5'd17, 16'd0},
    '{2'd2, 1'b0, 1'b1, 8'd0,   5'd19, 16'd10},
    '{2'd2, 1'b1, 1'b0, 8'd200, 5'd18, 16'd50},
    '{2'd2, 1'b0, 1'b0, 8'd1,   5'd19, 16'd0},
    '{2'd1, 1'b0, 1'b1, 8'd255, 5'd16, 16'd64}
  };

  // Expected event count: N * (256+M) * 2^E divided by the carry weight.
  function automatic longint want_events(int md, int m, int e, int n);
    longint stp, den;
    stp = longint'(256 + m) * (longint'(1) << e);
    den = (md == 0) ? 64'd16777216 : 64'd134217728;
    return (longint'(n) * stp) / den;
  endfunction

  function automatic bit want_err(int md, int m, int e);
    longint stp, lim;
    stp = longint'(256 + m) * (longint'(1) << e);
    case (md)
      0: lim = 64'd16777216;
      1: lim = 64'd33554432;
      2: lim = 64'd134217728;
      default: return 1'b0;
    endcase
    return stp > lim;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic setup(input int md, input bit pol, input bit pha,
                       input int m, input int e);
    @(negedge clk);
    mode = md[1:0]; cpol = pol; cpha = pha;
    cfg_we = 1'b1; cfg_mant = m[7:0]; cfg_exp = e[4:0];
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // Activate for exactly n clock edges, counting outputs after each edge.
  task automatic run(input int n);
    logic prev;
    c_tick = 0; c_bit = 0; c_tog = 0; c_smp = 0; c_shf = 0;
    c_badbit = 0; c_badspi = 0;
    @(negedge clk);
    prev = sck;
    active = 1'b1;
    for (int k = 0; k < n; k++) begin
      @(posedge clk); #1;
      if (tick16) c_tick++;
      if (bit_stb) begin
        c_bit++;
        if (!tick16 || (c_tick % 16) != 0) c_badbit++;
      end
      if (sample_stb) begin
        c_smp++;
        if (sck == prev || sck != (cpha ? cpol : !cpol)) c_badspi++;
      end
      if (shift_stb) begin
        c_shf++;
        if (sck == prev || sck != (cpha ? !cpol : cpol)) c_badspi++;
      end
      if (sck != prev) begin
        c_tog++;
        if (!(sample_stb ^ shift_stb)) c_badspi++;
      end
      prev = sck;
    end
    @(negedge clk);
    active = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; mode = 2'd0; active = 1'b0; cpol = 1'b0; cpha = 1'b0;
    cfg_we = 1'b0; cfg_mant = '0; cfg_exp = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // Reset state
    chk(!tick16 && !bit_stb && !sample_stb && !shift_stb, "R10", "strobes after reset",
        longint'({tick16, bit_stb, sample_stb, shift_stb}), 0);
    chk(sck == cpol, "R5", "sck after reset", sck, cpol);
    chk(rate_err == 1'b0, "R6", "err after reset", rate_err, 0);

    // Table of rate vectors
    for (int i = 0; i < NV; i++) begin
      vec_t v;
      longint ev;
      bit    eerr;
      v = VT[i];
      setup(int'(v.md), v.pol, v.pha, int'(v.m), int'(v.e));
      eerr = want_err(int'(v.md), int'(v.m), int'(v.e));
      chk(rate_err == eerr, "R6", $sformatf("err vec %0d", i), rate_err, eerr);
      if (!eerr) begin
        chk(sck == cpol, "R5", $sformatf("idle sck vec %0d", i), sck, cpol);
        run(int'(v.n));
        ev = want_events(int'(v.md), int'(v.m), int'(v.e), int'(v.n));
        if (v.md == 2'd0) begin
          chk(c_tick == ev, "R1", $sformatf("ticks vec %0d", i), c_tick, ev);
          chk(c_bit == ev / 16, "R2", $sformatf("bits vec %0d", i), c_bit, ev / 16);
          chk(c_badbit == 0, "R2", $sformatf("bit alignment vec %0d", i), c_badbit, 0);
        end else begin
          chk(c_tog == ev, "R3", $sformatf("sck edges vec %0d", i), c_tog, ev);
          chk(c_smp == (v.pha ? ev / 2 : (ev + 1) / 2), "R4",
              $sformatf("samples vec %0d", i), c_smp, v.pha ? ev / 2 : (ev + 1) / 2);
          chk(c_shf == (v.pha ? (ev + 1) / 2 : ev / 2), "R4",
              $sformatf("shifts vec %0d", i), c_shf, v.pha ? (ev + 1) / 2 : ev / 2);
          chk(c_badspi == 0, "R4", $sformatf("strobe/edge alignment vec %0d", i), c_badspi, 0);
        end
      end
    end

    // R9: restart phase. E=17,M=0 full duplex carries every 4 cycles.
    setup(1, 1'b0, 1'b0, 0, 17);
    run(6);
    chk(c_tog == 1, "R9", "first run edges", c_tog, 1);
    run(3);
    chk(c_tog == 0, "R9", "second run starts from zero phase", c_tog, 0);

    // R7: write while active is ignored
    setup(0, 1'b0, 1'b0, 0, 16);
    @(negedge clk);
    active = 1'b1;
    cfg_we = 1'b1; cfg_mant = 8'd3; cfg_exp = 5'd20;
    @(negedge clk);
    cfg_we = 1'b0;
    chk(rate_err == 1'b0, "R7", "err after write while active", rate_err, 0);
    active = 1'b0;
    @(negedge clk);
    chk(rate_err == 1'b0, "R7", "err after deactivation", rate_err, 0);
    run(5);
    chk(c_tick == 5, "R7", "old rate kept", c_tick, 5);

    // R8: slave mode quiet even with an extreme setting
    setup(3, 1'b1, 1'b0, 255, 31);
    chk(rate_err == 1'b0, "R8", "slave err", rate_err, 0);
    run(30);
    chk(c_tog + c_smp + c_shf + c_tick == 0, "R8", "slave activity",
        c_tog + c_smp + c_shf + c_tick, 0);
    chk(sck == 1'b1, "R8", "slave sck level", sck, 1);

    // R10: fast legal setting but port idle
    setup(0, 1'b0, 1'b0, 0, 16);
    c_tick = 0;
    for (int k = 0; k < 10; k++) begin
      @(posedge clk); #1;
      if (tick16 || bit_stb) c_tick++;
    end
    chk(c_tick == 0, "R10", "idle ticks", c_tick, 0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule